// File: doc/BRIEF.md
# Program/Erase Sequencer

This block takes commands that a serial front end has already decoded and runs the page program and sector erase operations of a flash memory as self-timed busy windows. The front end presents an 8-bit opcode and a 32-bit address word with a one-cycle `cmd_valid` strobe in the cycle where chip select goes high. The sequencer resolves the operation type, the source buffer, the first page and page count, and the sector, and holds them for the array model. It then keeps busy for a duration fixed by parameter: a normal program time, a shorter fast program time, or an erase time.

While busy, the sequencer reports busy both on an active-low ready/busy pin and on a status bit. It locks the flash array. A program also locks the buffer it reads from, and leaves the other buffer free. The erase address space has one small boot sector of 8 pages. A separate opcode reaches it, and its address field is wider. The remaining 64 large sectors have their own opcode: sector 0 of that group covers pages 8 to 255, and each other sector covers 256 pages.

Top module: `pe_sequencer`

## Requirements
- R1: Opcode 0x88 selects program from buffer 0 and opcode 0x89 selects program from buffer 1, both at normal speed. Opcode 0x98 selects program from buffer 0 and opcode 0x99 selects program from buffer 1, both at fast speed. `op_kind` reads 1 for a normal program and 2 for a fast program, and `op_buf` gives the buffer.
- R2: For a program, `op_first_page` is address bits [24:11], `op_page_count` is 1 and `op_sector` is page bits [13:8]. Address bits [31:25] and [10:0] have no effect.
- R3: Opcode 0x50 is the boot-sector erase (`op_kind` = 3). `op_first_page` is address bits [24:14] followed by three zero bits, and `op_page_count` is 8. All other address bits are ignored.
- R4: Opcode 0x7C is the large-sector erase (`op_kind` = 4), and `op_sector` is address bits [24:19]. Sector 0 gives first page 8 and count 248. Sector s>0 gives first page s*256 and count 256. Bits [18:0] are ignored.
- R5: A command accepted at a clock edge sets busy from that edge on, for exactly T_PROG, T_FPROG or T_ERASE cycles. During that time `status_busy` is 1 and `rdy_busy_n` is 0, and at all other times they take the opposite values.
- R6: While busy, `array_lock` is 1. During a program, `buf_lock` has only the bit of the source buffer set. During an erase, `buf_lock` is 0. When idle, all locks are 0.
- R7: A command is ignored while busy, including in the final busy cycle. An opcode outside the six above is also ignored. An ignored command changes neither the busy timing nor any `op_*` output.
- R8: Synchronous reset ends any running operation. After the reset edge, busy and all locks are 0 and `op_kind` is 0 (none). Reset takes priority over a command in the same cycle.
- R9: `op_start` is a one-cycle pulse in the first busy cycle of each accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe: command complete (chip select rising) |
| cmd_opcode | input | 8 | Decoded command opcode |
| cmd_addr | input | 32 | Four address bytes as one word |
| rdy_busy_n | output | 1 | Active-low ready/busy |
| status_busy | output | 1 | Status register busy bit (1 = busy) |
| array_lock | output | 1 | Flash array access blocked |
| buf_lock | output | 2 | Per-buffer access blocked |
| op_start | output | 1 | First cycle of an accepted operation |
| op_kind | output | 3 | 0 none, 1 program, 2 fast program, 3 boot erase, 4 sector erase |
| op_buf | output | 1 | Source buffer of a program |
| op_first_page | output | 14 | First page touched |
| op_page_count | output | 9 | Number of pages touched |
| op_sector | output | 6 | Large-sector index (page bits 13:8) |

## Verification
The end of a busy window and the arrival of a new command can fall on the same edge. The bench raises `cmd_valid` in the last cycle where it still observes busy, and expects the command to be dropped: `op_kind` keeps its value and busy does not reappear. A command one cycle later must be accepted. The bench also asserts reset in the same cycle as a command strobe, and expects no busy and a cleared `op_kind`.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;
    localparam int ADDR_W    = 32;
    localparam int OPC_W     = 8;
    localparam int PAGE_W    = 14;
    localparam int CNT_PG_W  = 9;
    localparam int SECT_W    = 6;
    localparam int NBUF      = 2;
    localparam int PAGE_LSB  = 11;
    localparam int BOOT_LSB  = PAGE_LSB + 3;
    localparam int BOOT_W    = PAGE_W - 3;
    localparam int SECT_LSB  = PAGE_LSB + PAGE_W - SECT_W;
    localparam int BOOT_PAGES = 8;
    localparam int BIG_PAGES  = 256;
    localparam int SECT0_PAGES = BIG_PAGES - BOOT_PAGES;

    localparam logic [OPC_W-1:0] OPC_PROG0  = 8'h88;
    localparam logic [OPC_W-1:0] OPC_PROG1  = 8'h89;
    localparam logic [OPC_W-1:0] OPC_FPROG0 = 8'h98;
    localparam logic [OPC_W-1:0] OPC_FPROG1 = 8'h99;
    localparam logic [OPC_W-1:0] OPC_ERBOOT = 8'h50;
    localparam logic [OPC_W-1:0] OPC_ERSECT = 8'h7C;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_PROG  = 3'd1,
        K_FPROG = 3'd2,
        K_ERB   = 3'd3,
        K_ERS   = 3'd4
    } op_kind_e;

    typedef struct packed {
        op_kind_e              kind;
        logic                  bsel;
        logic [PAGE_W-1:0]     first;
        logic [CNT_PG_W-1:0]   count;
        logic [SECT_W-1:0]     sect;
    } op_desc_t;

    function automatic op_desc_t decode_cmd(input logic [OPC_W-1:0] opc,
                                            input logic [ADDR_W-1:0] a);
        op_desc_t d;
        logic [PAGE_W-1:0] pg;
        logic [SECT_W-1:0] s;
        d  = '0;
        pg = a[PAGE_LSB +: PAGE_W];
        s  = a[SECT_LSB +: SECT_W];
        case (opc)
            OPC_PROG0, OPC_PROG1, OPC_FPROG0, OPC_FPROG1: begin
                d.kind  = (opc[4]) ? K_FPROG : K_PROG;
                d.bsel  = opc[0];
                d.first = pg;
                d.count = CNT_PG_W'(1);
                d.sect  = pg[PAGE_W-1 -: SECT_W];
            end
            OPC_ERBOOT: begin
                d.kind  = K_ERB;
                d.first = {a[BOOT_LSB +: BOOT_W], 3'b000};
                d.count = CNT_PG_W'(BOOT_PAGES);
                d.sect  = a[SECT_LSB +: SECT_W];
            end
            OPC_ERSECT: begin
                d.kind = K_ERS;
                d.sect = s;
                if (s == '0) begin
                    d.first = PAGE_W'(BOOT_PAGES);
                    d.count = CNT_PG_W'(SECT0_PAGES);
                end else begin
                    d.first = {s, 8'h00};
                    d.count = CNT_PG_W'(BIG_PAGES);
                end
            end
            default: d = '0;
        endcase
        return d;
    endfunction
endpackage

// File: rtl/pe_decode.sv
module pe_decode
    import pe_seq_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode,
    input  logic [ADDR_W-1:0] addr,
    output op_desc_t          desc,
    output logic              known
);
    always_comb begin
        desc  = decode_cmd(opcode, addr);
        known = (desc.kind != K_NONE);
    end
endmodule

// File: rtl/pe_timer.sv
module pe_timer
    import pe_seq_pkg::*;
#(
    parameter int T_PROG  = 5000,
    parameter int T_FPROG = 1500,
    parameter int T_ERASE = 20000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  op_kind_e kind,
    output logic     busy,
    output logic     start_pulse
);
    localparam int TMAX0 = (T_PROG > T_FPROG) ? T_PROG : T_FPROG;
    localparam int TMAX  = (TMAX0 > T_ERASE) ? TMAX0 : T_ERASE;
    localparam int CNT_W = $clog2(TMAX + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_v;

    always_comb begin
        case (kind)
            K_PROG:        load_v = CNT_W'(T_PROG - 1);
            K_FPROG:       load_v = CNT_W'(T_FPROG - 1);
            K_ERB, K_ERS:  load_v = CNT_W'(T_ERASE - 1);
            default:       load_v = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            cnt_q       <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            if (start && !busy) begin
                busy        <= 1'b1;
                cnt_q       <= load_v;
                start_pulse <= 1'b1;
            end else if (busy) begin
                if (cnt_q == '0) busy  <= 1'b0;
                else             cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != '0) |=> busy);
    p_end_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> ($past(cnt_q) == '0));
    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (busy && !$past(busy)));
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (!busy && !start_pulse));
endmodule

// File: rtl/pe_lock.sv
module pe_lock
    import pe_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            busy,
    input  op_kind_e        kind,
    input  logic            bsel,
    output logic            array_lock,
    output logic [NBUF-1:0] buf_lock
);
    logic is_prog;
    assign is_prog    = (kind == K_PROG) || (kind == K_FPROG);
    assign array_lock = busy;

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        assign buf_lock[b] = busy && is_prog && (bsel == b[0]);
    end

    p_buf_needs_array_r6: assert property (@(posedge clk) disable iff (rst)
        (|buf_lock) |-> array_lock);
    p_one_buf_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(buf_lock));
endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
    import pe_seq_pkg::*;
#(
    parameter int T_PROG  = 5000,
    parameter int T_FPROG = 1500,
    parameter int T_ERASE = 20000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd_opcode,
    input  logic [31:0]         cmd_addr,
    output logic                rdy_busy_n,
    output logic                status_busy,
    output logic                array_lock,
    output logic [1:0]          buf_lock,
    output logic                op_start,
    output logic [2:0]          op_kind,
    output logic                op_buf,
    output logic [13:0]         op_first_page,
    output logic [8:0]          op_page_count,
    output logic [5:0]          op_sector
);
    op_desc_t dec_desc;
    op_desc_t desc_q;
    logic     dec_known;
    logic     busy;
    logic     start_req;

    pe_decode u_dec (
        .opcode (cmd_opcode),
        .addr   (cmd_addr),
        .desc   (dec_desc),
        .known  (dec_known)
    );

    assign start_req = cmd_valid && dec_known && !busy;

    always_ff @(posedge clk) begin
        if (rst)            desc_q <= '0;
        else if (start_req) desc_q <= dec_desc;
    end

    pe_timer #(.T_PROG(T_PROG), .T_FPROG(T_FPROG), .T_ERASE(T_ERASE)) u_tmr (
        .clk         (clk),
        .rst         (rst),
        .start       (start_req),
        .kind        (dec_desc.kind),
        .busy        (busy),
        .start_pulse (op_start)
    );

    pe_lock u_lock (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .kind       (desc_q.kind),
        .bsel       (desc_q.bsel),
        .array_lock (array_lock),
        .buf_lock   (buf_lock)
    );

    assign status_busy   = busy;
    assign rdy_busy_n    = !busy;
    assign op_kind       = desc_q.kind;
    assign op_buf        = desc_q.bsel;
    assign op_first_page = desc_q.first;
    assign op_page_count = desc_q.count;
    assign op_sector     = desc_q.sect;

    p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> ($stable(desc_q) && !op_start));
    p_ignore_unknown_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !dec_known) |=> !op_start);
    p_start_cause_r9: assert property (@(posedge clk) disable iff (rst)
        op_start |-> $past(cmd_valid));
endmodule

// File: tb/sim_pe_sequencer.sv
module sim_pe_sequencer;
    localparam int TP = 24;
    localparam int TF = 9;
    localparam int TE = 37;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_opcode = '0;
    logic [31:0] cmd_addr = '0;
    logic        rdy_busy_n, status_busy, array_lock, op_start, op_buf;
    logic [1:0]  buf_lock;
    logic [2:0]  op_kind;
    logic [13:0] op_first_page;
    logic [8:0]  op_page_count;
    logic [5:0]  op_sector;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    pe_sequencer #(.T_PROG(TP), .T_FPROG(TF), .T_ERASE(TE)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .rdy_busy_n(rdy_busy_n), .status_busy(status_busy),
        .array_lock(array_lock), .buf_lock(buf_lock), .op_start(op_start),
        .op_kind(op_kind), .op_buf(op_buf), .op_first_page(op_first_page),
        .op_page_count(op_page_count), .op_sector(op_sector)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] opc, input logic [31:0] a);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_opcode = opc;
        cmd_addr   = a;
        @(negedge clk);
        cmd_valid  = 1'b0;
    endtask

    // counts busy samples from the current one (sample 1) on
    task automatic run_out(output int n);
        n = 0;
        while (status_busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset rdy_busy_n", rdy_busy_n, 1);
        chk("R8 reset status_busy", status_busy, 0);
        chk("R8 reset locks", {array_lock, buf_lock}, 0);
        chk("R8 reset op_kind", op_kind, 0);
    endtask

    task automatic t_prog(input logic [7:0] opc, input logic [31:0] a,
                          input int ebuf, input bit fast);
        int n;
        issue(opc, a);
        chk("R9 op_start first cycle", op_start, 1);
        chk("R1 op_kind", op_kind, fast ? 2 : 1);
        chk("R1 op_buf", op_buf, ebuf);
        chk("R2 first page", op_first_page, (a >> 11) & 32'h3FFF);
        chk("R2 page count", op_page_count, 1);
        chk("R2 sector", op_sector, (a >> 19) & 32'h3F);
        chk("R6 array lock", array_lock, 1);
        chk("R6 buffer lock", buf_lock, 1 << ebuf);
        chk("R5 rdy_busy_n low", rdy_busy_n, 0);
        @(negedge clk);
        chk("R9 op_start single", op_start, 0);
        run_out(n);
        chk("R5 program duration", n + 1, fast ? TF : TP);
        chk("R5 ready after", rdy_busy_n, 1);
        chk("R6 locks free", {array_lock, buf_lock}, 0);
    endtask

    task automatic t_boot(input logic [31:0] a);
        int n;
        int ef;
        ef = ((a >> 14) & 32'h7FF) << 3;
        issue(8'h50, a);
        chk("R3 op_kind", op_kind, 3);
        chk("R3 first page", op_first_page, ef);
        chk("R3 page count", op_page_count, 8);
        chk("R6 erase array lock", array_lock, 1);
        chk("R6 erase no buffer lock", buf_lock, 0);
        run_out(n);
        chk("R5 boot erase duration", n, TE);
    endtask

    task automatic t_sect(input int s);
        int n;
        issue(8'h7C, (s << 19) | 32'hFE07FFFF & ~(32'h3F << 19));
        chk("R4 op_kind", op_kind, 4);
        chk("R4 sector", op_sector, s);
        chk("R4 first page", op_first_page, (s == 0) ? 8 : s * 256);
        chk("R4 page count", op_page_count, (s == 0) ? 248 : 256);
        chk("R6 sector erase no buffer lock", buf_lock, 0);
        run_out(n);
        chk("R5 sector erase duration", n, TE);
    endtask

    task automatic t_busy_ignore();
        int n;
        issue(8'h88, 32'h0012_3800);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_opcode = 8'h7C; cmd_addr = 32'h00F8_0000;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7 busy ignore kind", op_kind, 1);
        chk("R7 busy ignore page", op_first_page, (32'h0012_3800 >> 11) & 32'h3FFF);
        chk("R7 busy ignore no start", op_start, 0);
        run_out(n);
        chk("R7 busy ignore duration", n + 2, TP);
    endtask

    task automatic t_last_cycle();
        issue(8'h99, 32'h0000_0800);
        repeat (TF - 1) @(negedge clk);
        chk("R7 still busy at last cycle", status_busy, 1);
        cmd_valid = 1'b1; cmd_opcode = 8'h89; cmd_addr = 32'h01FF_F800;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R7 last cycle command dropped", status_busy, 0);
        chk("R7 last cycle kind kept", op_kind, 2);
        chk("R7 last cycle buffer kept", op_buf, 1);
        chk("R7 last cycle page kept", op_first_page, 1);
        t_prog(8'h89, 32'h01FF_F800, 1, 0);
    endtask

    task automatic t_unknown();
        issue(8'h84, 32'h0000_0000);
        chk("R7 unknown opcode no busy", status_busy, 0);
        chk("R7 unknown opcode no start", op_start, 0);
        chk("R7 unknown opcode kind kept", op_kind, 1);
        chk("R7 unknown opcode page kept", op_first_page, 14'h3FFF);
    endtask

    task automatic t_reset_abort();
        issue(8'h7C, 32'h0100_0000);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R8 abort busy", status_busy, 0);
        chk("R8 abort locks", {array_lock, buf_lock}, 0);
        chk("R8 abort kind", op_kind, 0);
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b1; cmd_opcode = 8'h88; cmd_addr = 32'h0000_0800;
        @(negedge clk);
        rst = 1'b0; cmd_valid = 1'b0;
        @(negedge clk);
        chk("R8 reset beats command", status_busy, 0);
        chk("R8 reset beats command kind", op_kind, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        t_reset();
        t_prog(8'h88, 32'hFE00_07FF | (32'h2A5C << 11), 0, 0);
        t_prog(8'h98, 32'h0000_5800, 0, 1);
        t_prog(8'h99, 32'h01FF_F800, 1, 1);
        t_boot(32'h0000_0000);
        t_boot(32'hFFFF_FFFF);
        t_sect(0);
        t_sect(1);
        t_sect(63);
        t_busy_ignore();
        t_last_cycle();
        t_unknown();
        t_reset_abort();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule